// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds eight 32-bit general-purpose registers. Each access names a register index and a view width. The width selects the whole word, the low half-word, or a single byte. Byte views exist only for the first four registers. For each of those four, the byte view can pick bits 7:0 or bits 15:8.

A write at a narrow width merges into the stored word. Only the addressed lanes change and every other bit keeps its value. Narrow reads come back zero-extended to 32 bits. A reserved width code is refused: it raises an illegal flag on that port, blocks the write, and forces the read data to zero.

The file has one synchronous write port and two combinational read ports. A read and a write to the same register in the same cycle return the value held before the write.

Top module: `gpr_file`

## Requirements
- R1: After reset every register reads as 32'h0000_0000.
- R2: Width code 0 selects the full view. A full write replaces all 32 bits, and a full read returns all 32 bits, for each of the eight indices.
- R3: Width code 1 selects the word view. It is legal for all eight indices, and a word write replaces bits 15:0 while keeping bits 31:16.
- R4: Width code 2 selects the byte view. Byte indices 0 to 3 address bits 7:0 of registers 0 to 3, and a write there replaces only those 8 bits. Bits 31:8 of write data are ignored.
- R5: In the byte view, indices 4 to 7 address bits 15:8 of registers 0 to 3. A write there replaces only those 8 bits and leaves registers 4 to 7 untouched.
- R6: Word and byte reads return the selected bits in the low positions, with every higher bit of the read port at zero.
- R7: Width code 3 is reserved. On the write port it raises `wr_illegal` and changes no register. On a read port it raises that port's illegal flag and returns zero.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible after the clock edge.
- R9: The two read ports are independent: each may select any index and width at the same time as the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register / byte index |
| wr_width | input | 2 | Write view: 0 full, 1 word, 2 byte, 3 reserved |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| wr_illegal | output | 1 | Write view code is reserved |
| ra_idx | input | 3 | Port A index |
| ra_width | input | 2 | Port A view code |
| ra_data | output | 32 | Port A read data, zero-extended |
| ra_illegal | output | 1 | Port A view code is reserved |
| rb_idx | input | 3 | Port B index |
| rb_width | input | 2 | Port B view code |
| rb_data | output | 32 | Port B read data, zero-extended |
| rb_illegal | output | 1 | Port B view code is reserved |

## Verification
The bench preloads distinct words, then runs narrow writes whose results show lost bits. A merge bug would clear bits 31:16 or the neighbouring byte. A byte-index bug would hit registers 4 to 7 instead of the high byte of registers 0 to 3. Byte writes carry ones in their upper data bits, so a missing mask would spill them into the stored word. Reserved-code accesses are checked for both a blocked write and a zero read, and a same-cycle read-during-write checks that no bypass returns the new value early.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        VIEW_FULL = 2'd0,
        VIEW_WORD = 2'd1,
        VIEW_BYTE = 2'd2,
        VIEW_RSVD = 2'd3
    } view_e;

endpackage

// File: rtl/gpr_view_dec.sv
module gpr_view_dec
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int HALF_W   = 16,
    parameter int BYTE_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int BSEL_W  = IDX_W - 1,
    localparam int SHW     = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    input  view_e             width,
    output logic [IDX_W-1:0]  reg_sel,
    output logic [DATA_W-1:0] lane_mask,
    output logic [SHW-1:0]    lane_shift,
    output logic              legal
);

    always_comb begin
        reg_sel    = idx;
        lane_mask  = '1;
        lane_shift = '0;
        legal      = 1'b1;
        unique case (width)
            VIEW_FULL: ;
            VIEW_WORD: lane_mask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            VIEW_BYTE: begin
                // low half of the index picks one of the byte-capable registers,
                // the top index bit picks the lower or upper byte lane
                reg_sel    = {1'b0, idx[BSEL_W-1:0]};
                lane_shift = idx[IDX_W-1] ? SHW'(BYTE_W) : '0;
                lane_mask  = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << lane_shift;
            end
            default: begin
                lane_mask = '0;
                legal     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SHW     = $clog2(DATA_W)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]                idx,
    input  view_e                           width,
    output logic [DATA_W-1:0]               rdata,
    output logic                            illegal
);

    logic [IDX_W-1:0]  sel;
    logic [DATA_W-1:0] mask;
    logic [SHW-1:0]    shift;
    logic              legal;

    gpr_view_dec #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dec (
        .idx        (idx),
        .width      (width),
        .reg_sel    (sel),
        .lane_mask  (mask),
        .lane_shift (shift),
        .legal      (legal)
    );

    always_comb begin
        rdata   = legal ? ((regs[sel] & mask) >> shift) : '0;
        illegal = ~legal;
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SHW     = $clog2(DATA_W)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                sel,
    input  logic [DATA_W-1:0]               mask,
    input  logic [SHW-1:0]                  shift,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] placed;

    always_comb begin
        st_d     = st_q;
        cur_word = st_q.regs[sel];
        placed   = (wdata << shift) & mask;
        if (we) begin
            st_d.regs[sel] = (cur_word & ~mask) | placed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs = st_q.regs;

    // R7: no enabled write, no change anywhere in the bank
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (st_q.regs == $past(st_q.regs)))
        else $error("bank changed without write");

    // R3: bits outside the lane mask survive a write
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((st_q.regs[$past(sel)] & ~$past(mask)) == ($past(cur_word) & ~$past(mask))))
        else $error("unaddressed bits lost on write");

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int HALF_W   = 16,
    parameter int BYTE_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SHW     = $clog2(DATA_W),
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_width,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [1:0]        ra_width,
    output logic [DATA_W-1:0] ra_data,
    output logic              ra_illegal,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [1:0]        rb_width,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_illegal
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [IDX_W-1:0]  w_sel;
    logic [DATA_W-1:0] w_mask;
    logic [SHW-1:0]    w_shift;
    logic              w_legal;

    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][1:0]        rd_width;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
    logic [NUM_RD-1:0]             rd_illegal;

    gpr_view_dec #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
                   .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_wdec (
        .idx        (wr_idx),
        .width      (view_e'(wr_width)),
        .reg_sel    (w_sel),
        .lane_mask  (w_mask),
        .lane_shift (w_shift),
        .legal      (w_legal)
    );

    gpr_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en & w_legal),
        .sel   (w_sel),
        .mask  (w_mask),
        .shift (w_shift),
        .wdata (wr_data),
        .regs  (regs)
    );

    assign rd_idx   = {rb_idx, ra_idx};
    assign rd_width = {rb_width, ra_width};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
            .regs    (regs),
            .idx     (rd_idx[p]),
            .width   (view_e'(rd_width[p])),
            .rdata   (rd_data[p]),
            .illegal (rd_illegal[p])
        );
    end

    assign wr_illegal = ~w_legal;
    assign ra_data    = rd_data[0];
    assign rb_data    = rd_data[1];
    assign ra_illegal = rd_illegal[0];
    assign rb_illegal = rd_illegal[1];

    // R6: narrow reads are zero-extended on the port
    p_word_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_width == 2'd1) |-> (ra_data[DATA_W-1:HALF_W] == '0))
        else $error("word read not zero-extended");

    p_byte_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_width == 2'd2) |-> (rb_data[DATA_W-1:BYTE_W] == '0))
        else $error("byte read not zero-extended");

    // R7: a refused read returns zero
    p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ra_illegal |-> (ra_data == '0))
        else $error("illegal read returned data");

    // R5: a high-byte write touches only a byte-capable register's bits 15:8
    p_high_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_width == 2'd2 && wr_idx[IDX_W-1])
        |=> (regs[NUM_REGS-1:NUM_REGS/2] == $past(regs[NUM_REGS-1:NUM_REGS/2])))
        else $error("high-byte write reached an index-only register");

endmodule

// File: tb/sim_gpr_file.sv
module sim_gpr_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_width = '0;
    logic [31:0] wr_data = '0;
    logic        wr_illegal;
    logic [2:0]  ra_idx = '0;
    logic [1:0]  ra_width = '0;
    logic [31:0] ra_data;
    logic        ra_illegal;
    logic [2:0]  rb_idx = '0;
    logic [1:0]  rb_width = '0;
    logic [31:0] rb_data;
    logic        rb_illegal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpr_file u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width),
        .wr_data(wr_data), .wr_illegal(wr_illegal),
        .ra_idx(ra_idx), .ra_width(ra_width), .ra_data(ra_data), .ra_illegal(ra_illegal),
        .rb_idx(rb_idx), .rb_width(rb_width), .rb_data(rb_data), .rb_illegal(rb_illegal)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] idx, logic [1:0] w, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_width = w; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_a(logic [2:0] idx, logic [1:0] w, output logic [31:0] v);
        ra_idx = idx; ra_width = w; #1; v = ra_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_a(3'(i), 2'd0, v);
            check("R1 reset", v, 32'h0);
        end
    endtask

    task automatic t_full;
        logic [31:0] v;
        for (int i = 0; i < 8; i++) wr(3'(i), 2'd0, 32'h1111_1111 * (i + 1));
        for (int i = 0; i < 8; i++) begin
            rd_a(3'(i), 2'd0, v);
            check("R2 full", v, 32'h1111_1111 * (i + 1));
        end
        // R9: both ports at once, different views
        ra_idx = 3'd7; ra_width = 2'd0; rb_idx = 3'd2; rb_width = 2'd1; #1;
        check("R9 port A", ra_data, 32'h8888_8888);
        check("R9 port B", rb_data, 32'h0000_3333);
    endtask

    task automatic t_word;
        logic [31:0] v;
        wr(3'd0, 2'd1, 32'hFFFF_ABCD);
        rd_a(3'd0, 2'd0, v); check("R3 word merge reg0", v, 32'h1111_ABCD);
        rd_a(3'd0, 2'd1, v); check("R6 word read", v, 32'h0000_ABCD);
        wr(3'd6, 2'd1, 32'h0000_5A5A);
        rd_a(3'd6, 2'd0, v); check("R3 word merge reg6", v, 32'h7777_5A5A);
    endtask

    task automatic t_byte;
        logic [31:0] v;
        wr(3'd1, 2'd2, 32'h0000_009C);
        rd_a(3'd1, 2'd0, v); check("R4 low byte reg1", v, 32'h2222_229C);
        wr(3'd5, 2'd2, 32'h0000_003E);
        rd_a(3'd1, 2'd0, v); check("R5 high byte reg1", v, 32'h2222_3E9C);
        rd_a(3'd5, 2'd0, v); check("R5 reg5 untouched", v, 32'h6666_6666);
        rd_a(3'd5, 2'd2, v); check("R6 high byte read", v, 32'h0000_003E);
        rd_a(3'd1, 2'd2, v); check("R6 low byte read", v, 32'h0000_009C);
        wr(3'd3, 2'd2, 32'hFFFF_FF12);
        rd_a(3'd3, 2'd0, v); check("R4 upper data ignored", v, 32'h4444_4412);
        wr(3'd7, 2'd2, 32'h0000_00C7);
        rd_a(3'd3, 2'd0, v); check("R5 high byte reg3", v, 32'h4444_C712);
        rd_a(3'd7, 2'd0, v); check("R5 reg7 untouched", v, 32'h8888_8888);
    endtask

    task automatic t_illegal;
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_width = 2'd3; wr_data = 32'h0;
        #1; check("R7 wr_illegal", {31'b0, wr_illegal}, 32'h1);
        @(negedge clk);
        wr_en = 1'b0; wr_width = 2'd0;
        rd_a(3'd2, 2'd0, v); check("R7 no write", v, 32'h3333_3333);
        rd_a(3'd2, 2'd3, v); check("R7 read zero", v, 32'h0);
        check("R7 ra_illegal", {31'b0, ra_illegal}, 32'h1);
        ra_width = 2'd0;
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_width = 2'd0; wr_data = 32'hDEAD_BEEF;
        ra_idx = 3'd4; ra_width = 2'd0;
        #1; check("R8 old value before edge", ra_data, 32'h5555_5555);
        @(posedge clk); #1;
        check("R8 new value after edge", ra_data, 32'hDEAD_BEEF);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_word();
        t_byte();
        t_illegal();
        t_same_cycle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule